// File: doc/BRIEF.md
# Debug Event Trigger Unit

This block observes one on-chip bus port (valid, write flag, address, data), three single-bit event lines and a cross-trigger line from a neighbouring block. It raises a trigger when any programmed condition is met. There are six conditions: masked address compare, masked data compare, a write that lands in a protected address range, an event count passing a threshold, event A followed by event B inside a cycle window, and a rising cross-trigger. Each condition has its own enable bit, and the enabled conditions are ORed.

The trigger is registered. `trig_o` is high for exactly the cycle after each cycle in which an enabled condition holds. `sticky_o` records that a trigger has happened and stays high until software clears it. Software programs the unit through a small write-only register port. A register write takes effect on the following cycle. The control register clears the sticky flag and re-arms the stateful detectors.

Top module: `dbg_trig_unit`

## Requirements
- R1: After reset, `trig_o` and `sticky_o` are 0 and every configuration register is 0, so no condition is enabled.
- R2: Register 1 holds the address reference and register 2 the address mask. With enable bit 0 of the mode register (register 0) set, a valid access whose address equals the reference on every bit where the mask is 1 triggers. A mask bit of 0 ignores that bit. A cycle without valid never triggers.
- R3: Register 3 holds the data reference and register 4 the data mask. With mode bit 1 set, a valid access whose data matches under the mask triggers, using the same masking rule as R2.
- R4: Registers 5 and 6 hold the low and high bounds of the protected region. With mode bit 2 set, a valid write with low ≤ address ≤ high triggers, and both bounds count as inside. Reads and writes outside the region do not trigger.
- R5: Each cycle with `evt_cnt_i` high increments a counter. The counter saturates at all ones. With mode bit 3 set, the event that moves the counter from the threshold (register 7) to threshold+1 triggers, once. A threshold of all ones never triggers.
- R6: With mode bit 4 set, an `evt_b_i` in cycle t+k (1 ≤ k ≤ N, where N is register 8) after an `evt_a_i` in cycle t triggers. The window then closes. If no B arrives by cycle t+N, the detector goes back to waiting for A. A new A restarts the window. B in the same cycle as the opening A does not count.
- R7: With mode bit 5 set, a 0→1 edge on `xtrig_i` triggers once, however long the line stays high.
- R8: `trig_o` is high in the cycle after any cycle in which at least one enabled condition holds, and low otherwise. Conditions whose mode bit is 0 have no effect.
- R9: `sticky_o` rises together with `trig_o` and holds. Writing register 9 with bit 0 set clears it. A trigger in the same cycle as the clear wins.
- R10: Writing register 9 with bit 1 set re-arms the unit. The re-arm zeroes the event counter, closes any open sequence window, and suppresses the count and sequence conditions in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_valid_i | input | 1 | Bus access present this cycle |
| bus_we_i | input | 1 | Access is a write |
| bus_addr_i | input | AW | Access address |
| bus_data_i | input | DW | Access data |
| evt_a_i | input | 1 | Sequence opening event |
| evt_b_i | input | 1 | Sequence closing event |
| evt_cnt_i | input | 1 | Counted event |
| xtrig_i | input | 1 | Cross-trigger from another block |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 4 | Configuration register index |
| cfg_wdata_i | input | CFG_W | Configuration write data |
| trig_o | output | 1 | Trigger pulse |
| sticky_o | output | 1 | Trigger-seen flag |

## Verification
The bench builds the unit with 16-bit address and data, a 4-bit event counter and a 4-bit window register. With a 4-bit counter, saturation is reached in fifteen events, so both the never-firing all-ones threshold and the threshold-just-below-saturation case are exercised. With a 4-bit window, short windows make the last in-window cycle and the first expired cycle of the sequence detector easy to reach within a few cycles.

// File: rtl/dbg_trig_pkg.sv
package dbg_trig_pkg;
  localparam int NUM_COND = 6;
  localparam int C_ADDR   = 0;
  localparam int C_DATA   = 1;
  localparam int C_REGION = 2;
  localparam int C_COUNT  = 3;
  localparam int C_SEQ    = 4;
  localparam int C_XTRIG  = 5;

  localparam logic [3:0] CFG_MODE    = 4'd0;
  localparam logic [3:0] CFG_AVAL    = 4'd1;
  localparam logic [3:0] CFG_AMASK   = 4'd2;
  localparam logic [3:0] CFG_DVAL    = 4'd3;
  localparam logic [3:0] CFG_DMASK   = 4'd4;
  localparam logic [3:0] CFG_LO      = 4'd5;
  localparam logic [3:0] CFG_HI      = 4'd6;
  localparam logic [3:0] CFG_THRESH  = 4'd7;
  localparam logic [3:0] CFG_WINDOW  = 4'd8;
  localparam logic [3:0] CFG_CTRL    = 4'd9;
endpackage

// File: rtl/dbg_trig_cfg.sv
module dbg_trig_cfg import dbg_trig_pkg::*; #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int CW    = 16,
  parameter int WW    = 8,
  parameter int CFG_W = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [3:0]          addr_i,
  input  logic [CFG_W-1:0]    wdata_i,
  output logic [NUM_COND-1:0] mode_o,
  output logic [AW-1:0]       aval_o,
  output logic [AW-1:0]       amask_o,
  output logic [DW-1:0]       dval_o,
  output logic [DW-1:0]       dmask_o,
  output logic [AW-1:0]       lo_o,
  output logic [AW-1:0]       hi_o,
  output logic [CW-1:0]       thresh_o,
  output logic [WW-1:0]       window_o,
  output logic                clr_o,
  output logic                rearm_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o   <= '0;
      aval_o   <= '0;
      amask_o  <= '0;
      dval_o   <= '0;
      dmask_o  <= '0;
      lo_o     <= '0;
      hi_o     <= '0;
      thresh_o <= '0;
      window_o <= '0;
    end else if (we_i) begin
      case (addr_i)
        CFG_MODE:   mode_o   <= wdata_i[NUM_COND-1:0];
        CFG_AVAL:   aval_o   <= wdata_i[AW-1:0];
        CFG_AMASK:  amask_o  <= wdata_i[AW-1:0];
        CFG_DVAL:   dval_o   <= wdata_i[DW-1:0];
        CFG_DMASK:  dmask_o  <= wdata_i[DW-1:0];
        CFG_LO:     lo_o     <= wdata_i[AW-1:0];
        CFG_HI:     hi_o     <= wdata_i[AW-1:0];
        CFG_THRESH: thresh_o <= wdata_i[CW-1:0];
        CFG_WINDOW: window_o <= wdata_i[WW-1:0];
        default: ;
      endcase
    end
  end

  assign clr_o   = we_i && (addr_i == CFG_CTRL) && wdata_i[0];
  assign rearm_o = we_i && (addr_i == CFG_CTRL) && wdata_i[1];
endmodule

// File: rtl/dbg_trig_mcmp.sv
module dbg_trig_mcmp #(
  parameter int W = 32
) (
  input  logic [W-1:0] val_i,
  input  logic [W-1:0] ref_i,
  input  logic [W-1:0] mask_i,
  output logic         hit_o
);
  assign hit_o = ~|((val_i ^ ref_i) & mask_i);
endmodule

// File: rtl/dbg_trig_cnt.sv
module dbg_trig_cnt #(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rearm_i,
  input  logic          evt_i,
  input  logic [CW-1:0] thresh_i,
  output logic          hit_o
);
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (rearm_i)              cnt_q <= '0;
    else if (evt_i && cnt_q != CMAX) cnt_q <= cnt_q + 1'b1;
  end

  // fires only on the crossing step
  assign hit_o = !rearm_i && evt_i && (cnt_q == thresh_i) && (thresh_i != CMAX);
endmodule

// File: rtl/dbg_trig_seq.sv
module dbg_trig_seq #(
  parameter int WW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rearm_i,
  input  logic          evt_a_i,
  input  logic          evt_b_i,
  input  logic [WW-1:0] window_i,
  output logic          armed_o,
  output logic          hit_o
);
  logic [WW-1:0] rem_q;

  assign armed_o = (rem_q != '0);
  assign hit_o   = !rearm_i && armed_o && evt_b_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rem_q <= '0;
    else if (rearm_i) rem_q <= '0;
    else if (evt_a_i) rem_q <= window_i;
    else if (hit_o)   rem_q <= '0;
    else if (armed_o) rem_q <= rem_q - 1'b1;
  end
endmodule

// File: rtl/dbg_trig_unit.sv
module dbg_trig_unit import dbg_trig_pkg::*; #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int CW    = 16,
  parameter int WW    = 8,
  parameter int CFG_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bus_valid_i,
  input  logic             bus_we_i,
  input  logic [AW-1:0]    bus_addr_i,
  input  logic [DW-1:0]    bus_data_i,
  input  logic             evt_a_i,
  input  logic             evt_b_i,
  input  logic             evt_cnt_i,
  input  logic             xtrig_i,
  input  logic             cfg_we_i,
  input  logic [3:0]       cfg_addr_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  output logic             trig_o,
  output logic             sticky_o
);
  logic [NUM_COND-1:0] mode_q, cond;
  logic [AW-1:0] aval, amask, lo, hi;
  logic [DW-1:0] dval, dmask;
  logic [CW-1:0] thresh;
  logic [WW-1:0] window;
  logic clr, rearm, addr_eq, data_eq, cnt_hit, seq_hit, seq_armed;
  logic xtrig_q, any_hit, trig_q, sticky_q;

  dbg_trig_cfg #(.AW(AW), .DW(DW), .CW(CW), .WW(WW), .CFG_W(CFG_W)) u_cfg (
    .clk_i, .rst_ni, .we_i(cfg_we_i), .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i),
    .mode_o(mode_q), .aval_o(aval), .amask_o(amask), .dval_o(dval), .dmask_o(dmask),
    .lo_o(lo), .hi_o(hi), .thresh_o(thresh), .window_o(window),
    .clr_o(clr), .rearm_o(rearm)
  );

  dbg_trig_mcmp #(.W(AW)) u_acmp (.val_i(bus_addr_i), .ref_i(aval), .mask_i(amask), .hit_o(addr_eq));
  dbg_trig_mcmp #(.W(DW)) u_dcmp (.val_i(bus_data_i), .ref_i(dval), .mask_i(dmask), .hit_o(data_eq));

  dbg_trig_cnt #(.CW(CW)) u_cnt (
    .clk_i, .rst_ni, .rearm_i(rearm), .evt_i(evt_cnt_i), .thresh_i(thresh), .hit_o(cnt_hit)
  );

  dbg_trig_seq #(.WW(WW)) u_seq (
    .clk_i, .rst_ni, .rearm_i(rearm), .evt_a_i, .evt_b_i, .window_i(window),
    .armed_o(seq_armed), .hit_o(seq_hit)
  );

  always_comb begin
    cond           = '0;
    cond[C_ADDR]   = bus_valid_i && addr_eq;
    cond[C_DATA]   = bus_valid_i && data_eq;
    cond[C_REGION] = bus_valid_i && bus_we_i && (bus_addr_i >= lo) && (bus_addr_i <= hi);
    cond[C_COUNT]  = cnt_hit;
    cond[C_SEQ]    = seq_hit;
    cond[C_XTRIG]  = xtrig_i && !xtrig_q;
  end

  assign any_hit = |(cond & mode_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      xtrig_q  <= 1'b0;
      trig_q   <= 1'b0;
      sticky_q <= 1'b0;
    end else begin
      xtrig_q  <= xtrig_i;
      trig_q   <= any_hit;
      sticky_q <= any_hit || (sticky_q && !clr);
    end
  end

  assign trig_o   = trig_q;
  assign sticky_o = sticky_q;
endmodule

// File: rtl/dbg_trig_chk.sv
module dbg_trig_chk import dbg_trig_pkg::*; (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                trig_o,
  input logic                sticky_o,
  input logic                clr,
  input logic                rearm,
  input logic                xtrig_i,
  input logic                evt_b_i,
  input logic                seq_armed,
  input logic [NUM_COND-1:0] mode_q
);
  logic xtrig_seen;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) xtrig_seen <= 1'b0;
    else         xtrig_seen <= xtrig_i;
  end

  // R9
  trig_sets_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |-> sticky_o);

  // R9
  sticky_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sticky_o && !clr) |=> sticky_o);

  // R8
  mode_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == '0) |=> !trig_o);

  // R7
  xtrig_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q[C_XTRIG] && xtrig_i && !xtrig_seen) |=> trig_o);

  // R6
  seq_fire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q[C_SEQ] && seq_armed && evt_b_i && !rearm) |=> trig_o);
endmodule

bind dbg_trig_unit dbg_trig_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .trig_o(trig_o), .sticky_o(sticky_o),
  .clr(clr), .rearm(rearm), .xtrig_i(xtrig_i), .evt_b_i(evt_b_i),
  .seq_armed(seq_armed), .mode_q(mode_q)
);

// File: tb/sim_dbg_trig_unit.sv
module sim_dbg_trig_unit;
  localparam int AW = 16, DW = 16, CW = 4, WW = 4, CFG_W = 16;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic bus_valid = 0, bus_we = 0, evt_a = 0, evt_b = 0, evt_cnt = 0, xtrig = 0, cfg_we = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_data = '0;
  logic [3:0] cfg_addr = '0;
  logic [CFG_W-1:0] cfg_wdata = '0;
  logic trig_o, sticky_o;

  always #5 clk = ~clk;

  dbg_trig_unit #(.AW(AW), .DW(DW), .CW(CW), .WW(WW), .CFG_W(CFG_W)) u0 (
    .clk_i(clk), .rst_ni, .bus_valid_i(bus_valid), .bus_we_i(bus_we),
    .bus_addr_i(bus_addr), .bus_data_i(bus_data), .evt_a_i(evt_a), .evt_b_i(evt_b),
    .evt_cnt_i(evt_cnt), .xtrig_i(xtrig), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .trig_o, .sticky_o
  );

  // behavioural reference
  int m_reg [10];
  int m_cnt, m_rem;
  bit m_xprev, m_trig, m_sticky;
  bit m_clr, m_rearm, m_any;
  int m_mode;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      foreach (m_reg[i]) m_reg[i] = 0;
      m_cnt = 0; m_rem = 0; m_xprev = 0; m_trig = 0; m_sticky = 0;
    end else begin
      m_clr   = cfg_we && cfg_addr == 9 && cfg_wdata[0];
      m_rearm = cfg_we && cfg_addr == 9 && cfg_wdata[1];
      m_mode  = m_reg[0];
      m_any   = 0;
      if ((m_mode & 1) && bus_valid && (((int'(bus_addr) ^ m_reg[1]) & m_reg[2]) == 0)) m_any = 1;
      if ((m_mode & 2) && bus_valid && (((int'(bus_data) ^ m_reg[3]) & m_reg[4]) == 0)) m_any = 1;
      if ((m_mode & 4) && bus_valid && bus_we && int'(bus_addr) >= m_reg[5] && int'(bus_addr) <= m_reg[6]) m_any = 1;
      if ((m_mode & 8) && !m_rearm && evt_cnt && m_cnt == m_reg[7] && m_reg[7] < CMAX) m_any = 1;
      if ((m_mode & 16) && !m_rearm && m_rem > 0 && evt_b) m_any = 1;
      if ((m_mode & 32) && xtrig && !m_xprev) m_any = 1;
      // state
      if (m_rearm) m_cnt = 0;
      else if (evt_cnt && m_cnt < CMAX) m_cnt++;
      if (m_rearm) m_rem = 0;
      else if (evt_a) m_rem = m_reg[8];
      else if (m_rem > 0 && evt_b) m_rem = 0;
      else if (m_rem > 0) m_rem--;
      m_xprev  = xtrig;
      m_trig   = m_any;
      m_sticky = m_any || (m_sticky && !m_clr);
      if (cfg_we && cfg_addr < 9) begin
        case (cfg_addr)
          0: m_reg[0] = int'(cfg_wdata) & 63;
          7: m_reg[7] = int'(cfg_wdata) & CMAX;
          8: m_reg[8] = int'(cfg_wdata) & ((1 << WW) - 1);
          default: m_reg[cfg_addr] = int'(cfg_wdata);
        endcase
      end
    end
  end

  int n_checks = 0, n_fail = 0;
  string phase = "R1";

  task automatic check(string req, string what, logic act, logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    check(phase, "trig_o vs model", trig_o, m_trig);
    check(phase, "sticky_o vs model", sticky_o, m_sticky);
  endtask

  task automatic want(string req, logic exp);
    check(req, "trig_o direct", trig_o, exp);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic wr(logic [3:0] a, logic [CFG_W-1:0] d);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    tick();
    cfg_we = 0;
  endtask

  task automatic acc(logic we, logic [AW-1:0] a, logic [DW-1:0] d);
    bus_valid = 1; bus_we = we; bus_addr = a; bus_data = d;
    tick();
    bus_valid = 0; bus_we = 0;
  endtask

  task automatic pa(); evt_a = 1; tick(); evt_a = 0; endtask
  task automatic pb(); evt_b = 1; tick(); evt_b = 0; endtask
  task automatic pc(); evt_cnt = 1; tick(); evt_cnt = 0; endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    // R1 reset state
    check("R1", "trig_o reset", trig_o, 1'b0);
    check("R1", "sticky_o reset", sticky_o, 1'b0);
    acc(1, 16'h0000, 16'h0000); want("R1", 0);
    xtrig = 1; tick(); xtrig = 0; want("R1", 0);

    phase = "R2";
    wr(1, 16'h1234); wr(2, 16'hFFFF); wr(0, 16'h0001);
    acc(0, 16'h1234, 16'h0); want("R2", 1);
    tick(); want("R2", 0);
    acc(0, 16'h1235, 16'h0); want("R2", 0);
    bus_addr = 16'h1234; bus_valid = 0; tick(); want("R2", 0);
    wr(2, 16'hFFF0);
    acc(1, 16'h123F, 16'h0); want("R2", 1);
    acc(1, 16'h124F, 16'h0); want("R2", 0);

    phase = "R9";
    wr(9, 16'h0001); check("R9", "sticky cleared", sticky_o, 1'b0);
    wr(0, 16'h0001);
    cfg_we = 1; cfg_addr = 9; cfg_wdata = 16'h0001;
    bus_valid = 1; bus_addr = 16'h1230;
    tick(); cfg_we = 0; bus_valid = 0;
    check("R9", "set beats clear", sticky_o, 1'b1);
    idle(3); check("R9", "sticky holds", sticky_o, 1'b1);
    wr(9, 16'h0001);

    phase = "R3";
    wr(3, 16'hBEEF); wr(4, 16'hFF00); wr(0, 16'h0002);
    acc(0, 16'h0, 16'hBE00); want("R3", 1);
    acc(0, 16'h0, 16'hBF00); want("R3", 0);
    acc(0, 16'h0, 16'hBE77); want("R3", 1);

    phase = "R4";
    wr(5, 16'h0100); wr(6, 16'h01FF); wr(0, 16'h0004);
    acc(1, 16'h00FF, 16'h0); want("R4", 0);
    acc(1, 16'h0100, 16'h0); want("R4", 1);
    acc(1, 16'h01FF, 16'h0); want("R4", 1);
    acc(1, 16'h0200, 16'h0); want("R4", 0);
    acc(0, 16'h0150, 16'h0); want("R4", 0);

    phase = "R5";
    wr(7, 16'd3); wr(0, 16'h0008); wr(9, 16'h0002);
    for (int i = 1; i <= 6; i++) begin pc(); want("R5", i == 4); end
    wr(7, 16'd15); wr(9, 16'h0002);
    for (int i = 1; i <= 20; i++) begin pc(); want("R5", 0); end
    wr(7, 16'd14); wr(9, 16'h0002);
    for (int i = 1; i <= 18; i++) begin pc(); want("R5", i == 15); end

    phase = "R6";
    wr(8, 16'd3); wr(0, 16'h0010);
    pa(); pb(); want("R6", 1);
    pa(); idle(2); pb(); want("R6", 1);
    pa(); idle(3); pb(); want("R6", 0);
    evt_a = 1; evt_b = 1; tick(); evt_a = 0; evt_b = 0; want("R6", 0);
    idle(4);
    pa(); idle(1); pa(); idle(2); pb(); want("R6", 1);
    pa(); pb(); pb(); want("R6", 0);

    phase = "R10";
    pa(); wr(9, 16'h0002); pb(); want("R10", 0);
    pa(); evt_b = 1; cfg_we = 1; cfg_addr = 9; cfg_wdata = 16'h0002; tick();
    evt_b = 0; cfg_we = 0; want("R10", 0);
    wr(7, 16'd1); wr(0, 16'h0008);
    pc(); wr(9, 16'h0002); pc(); want("R10", 0); pc(); want("R10", 1);

    phase = "R7";
    wr(0, 16'h0020);
    xtrig = 1; tick(); want("R7", 1);
    tick(); want("R7", 0); tick(); want("R7", 0);
    xtrig = 0; tick(); xtrig = 1; tick(); want("R7", 1); xtrig = 0;

    phase = "R8";
    wr(9, 16'h0003); wr(0, 16'h0021);
    acc(0, 16'h1230, 16'h0); want("R8", 1);
    xtrig = 1; tick(); xtrig = 0; want("R8", 1);
    pa(); pb(); want("R8", 0);
    wr(0, 16'h0000);
    acc(1, 16'h0150, 16'hBE00); want("R8", 0);
    wr(0, 16'h003F);
    bus_valid = 1; bus_we = 1; bus_addr = 16'h1230; bus_data = 16'hBE00; xtrig = 1;
    tick(); bus_valid = 0; bus_we = 0; xtrig = 0; want("R8", 1);
    tick(); want("R8", 0);
    idle(2);
    finish_run();
  end
endmodule